// File: doc/BRIEF.md
# System Control Port Block with I/O Window Translator

This block sits behind a byte-wide I/O port bus in a legacy-style system controller. It decodes a 16-bit port address with separate read and write strobes. It holds the level outputs that software controls: a soft-reset request, a little-endian mode select, a disk-activity indicator, a 4-bit system-control field and the I/O map-mode bit. Writes to two lock ports each produce a single-cycle toggle strobe toward an external NVRAM. A set of fixed identification bytes is returned on reads. Two scratch bytes give software a small read/write store.

Alongside the registers, a combinational translator converts a 23-bit offset inside the CPU-side I/O window into an ISA port number. When the map-mode bit is clear, the window is flat. When it is set, the window is sparse and the page bits of the offset are regrouped next to the low byte-select bits.

Top module: `sysport_ctl`

## Requirements
- R1: A write to port 0x0092 sets `softReset` to data bit 0 and `littleEndian` to data bit 1, both as levels, visible one clock after the write strobe.
- R2: A read of port 0x0092 returns 0x00 regardless of what was last written.
- R3: A write to port 0x0808 sets `diskLed` to data bit 0; no other register or output changes.
- R4: A write to port 0x081C stores data bits [3:0] on `sysCtl`; a read of 0x081C returns that nibble in bits [3:0] with bits [7:4] zero.
- R5: A write to port 0x0850 stores data bit 0 as `sparseMap`; a read of 0x0850 returns it in bit 0 with the other bits zero.
- R6: A write to port 0x0810 raises `lockPulse1` high for exactly one clock, starting one clock after the write; a write to 0x0812 does the same on `lockPulse2`.
- R7: Reads of the identification ports return fixed bytes: 0x0800→0xEF, 0x0802→0xAD, 0x0803→0xE0, 0x080C→0x3C, 0x0810→0x39, 0x0818→0x00, 0x0823→0x03; writes to 0x0800, 0x0802 and 0x0803 change nothing.
- R8: A read of any other port, including 0x0814, returns 0xFF, and a write to such a port changes nothing.
- R9: Ports 0x0398 and 0x0399 are two independent 8-bit read/write scratch bytes.
- R10: With `sparseMap` at 0, `portAddr` equals `winOffset[15:0]`, combinationally.
- R11: With `sparseMap` at 1, `portAddr` is {`winOffset[22:12]`, `winOffset[4:0]`}, combinationally.
- R12: Synchronous active-high reset clears every register and output to zero, which selects the flat map.
- R13: Read data is registered and appears on `ioRdData` one clock after a read strobe. It holds otherwise. When both strobes are high, the cycle is a write only, and `ioRdData` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ioAddr | input | 16 | I/O port address |
| ioWrEn | input | 1 | Write strobe, one cycle per access |
| ioRdEn | input | 1 | Read strobe, one cycle per access |
| ioWrData | input | 8 | Write data |
| ioRdData | output | 8 | Registered read data |
| softReset | output | 1 | Soft-reset request level |
| littleEndian | output | 1 | Little-endian mode select |
| diskLed | output | 1 | Disk-activity indicator |
| sysCtl | output | 4 | System-control field |
| sparseMap | output | 1 | I/O map mode: 0 flat, 1 sparse |
| lockPulse1 | output | 1 | NVRAM lock 1 toggle strobe |
| lockPulse2 | output | 1 | NVRAM lock 2 toggle strobe |
| winOffset | input | 23 | Offset within the CPU-side I/O window |
| portAddr | output | 16 | Translated ISA port address |

## Verification
Register outputs and lock strobes change at the first rising edge after a write strobe. The bench drives strobes on a falling edge and samples at the next falling edge. Lock strobes are checked again one clock later to confirm they have dropped. Read data is due one edge after the read strobe and is sampled at the next falling edge. The translator has no registers, so it is checked a quarter cycle after `winOffset` changes, once the map-mode write has settled.

// File: rtl/sysport_pkg.sv
package sysport_pkg;
  localparam int PORT_W = 16;
  localparam int DATA_W = 8;

  localparam logic [PORT_W-1:0] P_SYSRST = 16'h0092;
  localparam logic [PORT_W-1:0] P_CPUCFG = 16'h0800;
  localparam logic [PORT_W-1:0] P_FEAT   = 16'h0802;
  localparam logic [PORT_W-1:0] P_STAT   = 16'h0803;
  localparam logic [PORT_W-1:0] P_DISK   = 16'h0808;
  localparam logic [PORT_W-1:0] P_EQUIP  = 16'h080C;
  localparam logic [PORT_W-1:0] P_LOCK1  = 16'h0810;
  localparam logic [PORT_W-1:0] P_LOCK2  = 16'h0812;
  localparam logic [PORT_W-1:0] P_KEY    = 16'h0818;
  localparam logic [PORT_W-1:0] P_SYSCTL = 16'h081C;
  localparam logic [PORT_W-1:0] P_CACHE  = 16'h0823;
  localparam logic [PORT_W-1:0] P_MAP    = 16'h0850;
  localparam logic [PORT_W-1:0] P_SCR0   = 16'h0398;
  localparam logic [PORT_W-1:0] P_SCR1   = 16'h0399;

  typedef enum logic [2:0] {
    RS_CONST  = 3'd0,
    RS_SYSCTL = 3'd1,
    RS_MAP    = 3'd2,
    RS_SCR0   = 3'd3,
    RS_SCR1   = 3'd4
  } rdSel_e;

  typedef struct packed {
    logic              wrRst;
    logic              wrDisk;
    logic              wrSysCtl;
    logic              wrMap;
    logic              wrLock1;
    logic              wrLock2;
    logic              wrScr0;
    logic              wrScr1;
    logic              rdLoad;
    rdSel_e            rdSel;
    logic [DATA_W-1:0] rdConst;
  } portStb_t;
endpackage

// File: rtl/sysport_decode.sv
module sysport_decode
  import sysport_pkg::*;
(
  input  logic [PORT_W-1:0] ioAddr,
  input  logic              ioWrEn,
  input  logic              ioRdEn,
  output portStb_t          stb
);
  logic rdOnly;
  assign rdOnly = ioRdEn && !ioWrEn;

  always_comb begin
    stb          = '0;
    stb.rdSel    = RS_CONST;
    stb.rdConst  = 8'hFF;
    stb.rdLoad   = rdOnly;
    case (ioAddr)
      P_SYSRST: begin stb.wrRst    = ioWrEn; stb.rdConst = 8'h00; end
      P_CPUCFG: stb.rdConst = 8'hEF;
      P_FEAT:   stb.rdConst = 8'hAD;
      P_STAT:   stb.rdConst = 8'hE0;
      P_DISK:   stb.wrDisk = ioWrEn;
      P_EQUIP:  stb.rdConst = 8'h3C;
      P_LOCK1:  begin stb.wrLock1  = ioWrEn; stb.rdConst = 8'h39; end
      P_LOCK2:  stb.wrLock2 = ioWrEn;
      P_KEY:    stb.rdConst = 8'h00;
      P_SYSCTL: begin stb.wrSysCtl = ioWrEn; stb.rdSel = RS_SYSCTL; end
      P_CACHE:  stb.rdConst = 8'h03;
      P_MAP:    begin stb.wrMap    = ioWrEn; stb.rdSel = RS_MAP; end
      P_SCR0:   begin stb.wrScr0   = ioWrEn; stb.rdSel = RS_SCR0; end
      P_SCR1:   begin stb.wrScr1   = ioWrEn; stb.rdSel = RS_SCR1; end
      default:  ;
    endcase
  end
endmodule

// File: rtl/sysport_regs.sv
module sysport_regs
  import sysport_pkg::*;
#(
  parameter int CTL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  portStb_t          stb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              softReset,
  output logic              littleEndian,
  output logic              diskLed,
  output logic [CTL_W-1:0]  sysCtl,
  output logic              sparseMap,
  output logic              lockPulse1,
  output logic              lockPulse2
);
  localparam int PAD_W = DATA_W - CTL_W;

  logic [DATA_W-1:0] scr0, scr1, rdNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      softReset    <= 1'b0;
      littleEndian <= 1'b0;
      diskLed      <= 1'b0;
      sysCtl       <= '0;
      sparseMap    <= 1'b0;
      lockPulse1   <= 1'b0;
      lockPulse2   <= 1'b0;
      scr0         <= '0;
      scr1         <= '0;
    end else begin
      lockPulse1 <= stb.wrLock1;
      lockPulse2 <= stb.wrLock2;
      if (stb.wrRst) begin
        softReset    <= wrData[0];
        littleEndian <= wrData[1];
      end
      if (stb.wrDisk)   diskLed   <= wrData[0];
      if (stb.wrSysCtl) sysCtl    <= wrData[CTL_W-1:0];
      if (stb.wrMap)    sparseMap <= wrData[0];
      if (stb.wrScr0)   scr0      <= wrData;
      if (stb.wrScr1)   scr1      <= wrData;
    end
  end

  always_comb begin
    case (stb.rdSel)
      RS_SYSCTL: rdNext = {{PAD_W{1'b0}}, sysCtl};
      RS_MAP:    rdNext = {{(DATA_W-1){1'b0}}, sparseMap};
      RS_SCR0:   rdNext = scr0;
      RS_SCR1:   rdNext = scr1;
      default:   rdNext = stb.rdConst;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)             rdData <= '0;
    else if (stb.rdLoad) rdData <= rdNext;
  end

  // R1: reset/endian follow the written bits one clock later
  a_r1_rst_level: assert property (@(posedge clk) disable iff (rst)
    stb.wrRst |=> (softReset == $past(wrData[0])) && (littleEndian == $past(wrData[1])));
  // R6: no strobe without a lock write in the previous cycle
  a_r6_lock1_quiet: assert property (@(posedge clk) disable iff (rst)
    !stb.wrLock1 |=> !lockPulse1);
  a_r6_lock2_quiet: assert property (@(posedge clk) disable iff (rst)
    !stb.wrLock2 |=> !lockPulse2);
  // R9: scratch bytes hold without their own write
  a_r9_scr_hold: assert property (@(posedge clk) disable iff (rst)
    !stb.wrScr0 |=> $stable(scr0));
endmodule

// File: rtl/sysport_xlate.sv
module sysport_xlate #(
  parameter int WIN_W    = 23,
  parameter int PORT_W   = 16,
  parameter int LOW_W    = 5,
  parameter int PAGE_LSB = 12
) (
  input  logic              sparseMap,
  input  logic [WIN_W-1:0]  winOffset,
  output logic [PORT_W-1:0] portAddr
);
  localparam int PAGE_W = WIN_W - PAGE_LSB;
  localparam int SP_W   = PAGE_W + LOW_W;

  logic [SP_W-1:0] sparseAddr;
  assign sparseAddr = {winOffset[WIN_W-1:PAGE_LSB], winOffset[LOW_W-1:0]};

  generate
    if (SP_W >= PORT_W) begin : g_fit
      assign portAddr = sparseMap ? sparseAddr[PORT_W-1:0] : winOffset[PORT_W-1:0];
    end else begin : g_pad
      assign portAddr = sparseMap ? {{(PORT_W-SP_W){1'b0}}, sparseAddr}
                                  : winOffset[PORT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/sysport_ctl.sv
module sysport_ctl
  import sysport_pkg::*;
#(
  parameter int WIN_W = 23,
  parameter int CTL_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_W-1:0] ioAddr,
  input  logic              ioWrEn,
  input  logic              ioRdEn,
  input  logic [DATA_W-1:0] ioWrData,
  output logic [DATA_W-1:0] ioRdData,
  output logic              softReset,
  output logic              littleEndian,
  output logic              diskLed,
  output logic [CTL_W-1:0]  sysCtl,
  output logic              sparseMap,
  output logic              lockPulse1,
  output logic              lockPulse2,
  input  logic [WIN_W-1:0]  winOffset,
  output logic [PORT_W-1:0] portAddr
);
  portStb_t stb;

  sysport_decode u_decode (
    .ioAddr (ioAddr),
    .ioWrEn (ioWrEn),
    .ioRdEn (ioRdEn),
    .stb    (stb)
  );

  sysport_regs #(.CTL_W(CTL_W)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .stb          (stb),
    .wrData       (ioWrData),
    .rdData       (ioRdData),
    .softReset    (softReset),
    .littleEndian (littleEndian),
    .diskLed      (diskLed),
    .sysCtl       (sysCtl),
    .sparseMap    (sparseMap),
    .lockPulse1   (lockPulse1),
    .lockPulse2   (lockPulse2)
  );

  sysport_xlate #(.WIN_W(WIN_W), .PORT_W(PORT_W)) u_xlate (
    .sparseMap (sparseMap),
    .winOffset (winOffset),
    .portAddr  (portAddr)
  );

  // R2: the reset port always reads zero
  a_r2_rst_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (ioRdEn && !ioWrEn && ioAddr == P_SYSRST) |=> ioRdData == '0);
  // R4: upper bits of the control read are zero
  a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (ioRdEn && !ioWrEn && ioAddr == P_SYSCTL) |=> ioRdData[7:4] == 4'h0);
  // R13: read data holds without a read-only cycle
  a_r13_rd_hold: assert property (@(posedge clk) disable iff (rst)
    (!ioRdEn || ioWrEn) |=> $stable(ioRdData));
  // R3: the indicator moves only on its own port
  a_r3_led_hold: assert property (@(posedge clk) disable iff (rst)
    !(ioWrEn && ioAddr == P_DISK) |=> $stable(diskLed));
  // R11: sparse map keeps the byte-select bits
  a_r11_low_bits: assert property (@(posedge clk) disable iff (rst)
    sparseMap |-> portAddr[4:0] == winOffset[4:0]);
endmodule

// File: tb/tb_sysport_ctl.sv
`timescale 1ns/1ps
module tb_sysport_ctl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ioAddr = '0;
  logic        ioWrEn = 1'b0, ioRdEn = 1'b0;
  logic [7:0]  ioWrData = '0;
  logic [7:0]  ioRdData;
  logic        softReset, littleEndian, diskLed, sparseMap, lockPulse1, lockPulse2;
  logic [3:0]  sysCtl;
  logic [22:0] winOffset = '0;
  logic [15:0] portAddr;

  int nTests = 0;
  int nFail  = 0;

  always #10 clk = ~clk;

  sysport_ctl dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic ioWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); ioAddr = a; ioWrData = d; ioWrEn = 1'b1;
    @(negedge clk); ioWrEn = 1'b0;
  endtask

  task automatic ioRead(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); ioAddr = a; ioRdEn = 1'b1;
    @(negedge clk); d = ioRdData; ioRdEn = 1'b0;
  endtask

  task automatic t_reset();
    check("R12 softReset", softReset, 0);
    check("R12 littleEndian", littleEndian, 0);
    check("R12 diskLed", diskLed, 0);
    check("R12 sysCtl", sysCtl, 0);
    check("R12 sparseMap", sparseMap, 0);
    check("R12 lock pulses", {lockPulse1, lockPulse2}, 0);
    check("R12 rdData", ioRdData, 0);
  endtask

  task automatic t_port92();
    logic [7:0] d;
    ioWrite(16'h0092, 8'h03);
    check("R1 softReset set", softReset, 1);
    check("R1 littleEndian set", littleEndian, 1);
    ioRead(16'h0092, d);
    check("R2 read zero", d, 8'h00);
    ioWrite(16'h0092, 8'hFE);
    check("R1 softReset clear", softReset, 0);
    check("R1 littleEndian kept", littleEndian, 1);
    ioWrite(16'h0092, 8'h00);
    check("R1 littleEndian clear", littleEndian, 0);
  endtask

  task automatic t_disk();
    ioWrite(16'h081C, 8'h0A);
    ioWrite(16'h0808, 8'hFF);
    check("R3 led set", diskLed, 1);
    check("R3 sysCtl untouched", sysCtl, 4'hA);
    check("R3 reset untouched", softReset, 0);
    ioWrite(16'h0808, 8'hFE);
    check("R3 led clear", diskLed, 0);
  endtask

  task automatic t_sysctl();
    logic [7:0] d;
    ioWrite(16'h081C, 8'hF5);
    check("R4 nibble stored", sysCtl, 4'h5);
    ioRead(16'h081C, d);
    check("R4 read nibble", d, 8'h05);
  endtask

  task automatic t_locks();
    @(negedge clk); ioAddr = 16'h0810; ioWrEn = 1'b1;
    @(negedge clk); ioWrEn = 1'b0;
    check("R6 lock1 high", lockPulse1, 1);
    check("R6 lock2 low", lockPulse2, 0);
    @(negedge clk);
    check("R6 lock1 single", lockPulse1, 0);
    @(negedge clk); ioAddr = 16'h0812; ioWrEn = 1'b1;
    @(negedge clk); ioWrEn = 1'b0;
    check("R6 lock2 high", lockPulse2, 1);
    check("R6 lock1 low", lockPulse1, 0);
    @(negedge clk);
    check("R6 lock2 single", lockPulse2, 0);
  endtask

  task automatic t_ids();
    logic [7:0] d;
    ioWrite(16'h0800, 8'h00);
    ioWrite(16'h0802, 8'h00);
    ioWrite(16'h0803, 8'h00);
    ioRead(16'h0800, d); check("R7 0800", d, 8'hEF);
    ioRead(16'h0802, d); check("R7 0802", d, 8'hAD);
    ioRead(16'h0803, d); check("R7 0803", d, 8'hE0);
    ioRead(16'h080C, d); check("R7 080C", d, 8'h3C);
    ioRead(16'h0810, d); check("R7 0810", d, 8'h39);
    ioRead(16'h0818, d); check("R7 0818", d, 8'h00);
    ioRead(16'h0823, d); check("R7 0823", d, 8'h03);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    ioWrite(16'h0814, 8'h00);
    ioWrite(16'h0830, 8'h00);
    ioRead(16'h0814, d); check("R8 0814", d, 8'hFF);
    ioRead(16'h0830, d); check("R8 0830", d, 8'hFF);
    ioRead(16'h1234, d); check("R8 1234", d, 8'hFF);
    check("R8 sysCtl untouched", sysCtl, 4'h5);
  endtask

  task automatic t_scratch();
    logic [7:0] d;
    ioWrite(16'h0398, 8'h5A);
    ioWrite(16'h0399, 8'hC3);
    ioRead(16'h0398, d); check("R9 scratch0", d, 8'h5A);
    ioRead(16'h0399, d); check("R9 scratch1", d, 8'hC3);
    ioWrite(16'h0399, 8'h11);
    ioRead(16'h0398, d); check("R9 scratch0 independent", d, 8'h5A);
  endtask

  task automatic t_xlate();
    logic [7:0] d;
    winOffset = 23'h2AB0C5;
    #5 check("R10 flat", portAddr, 16'hB0C5);
    ioWrite(16'h0850, 8'hFF);
    check("R5 map set", sparseMap, 1);
    ioRead(16'h0850, d); check("R5 map read", d, 8'h01);
    #5 check("R11 sparse", portAddr, 16'h5565);
    winOffset = 23'h7FF01F;
    #1 check("R11 sparse all ones", portAddr, 16'hFFFF);
    ioWrite(16'h0850, 8'h00);
    check("R5 map clear", sparseMap, 0);
    #1 check("R10 flat again", portAddr, 16'hF01F);
  endtask

  task automatic t_rdwr();
    logic [7:0] d;
    ioRead(16'h0802, d);
    @(negedge clk); ioAddr = 16'h081C; ioWrData = 8'h09; ioWrEn = 1'b1; ioRdEn = 1'b1;
    @(negedge clk); ioWrEn = 1'b0; ioRdEn = 1'b0;
    check("R13 rdData held", ioRdData, 8'hAD);
    check("R13 write taken", sysCtl, 4'h9);
    @(negedge clk);
    check("R13 rdData still held", ioRdData, 8'hAD);
  endtask

  initial begin
    #(20 * 100000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_port92();
    t_disk();
    t_sysctl();
    t_locks();
    t_ids();
    t_unmapped();
    t_scratch();
    t_xlate();
    t_rdwr();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule